// File: doc/BRIEF.md
# Three-Source Serial Interrupt Level and Vector Arbiter

This block gathers the interrupt requests of three serial engines into one prioritised request toward a CPU. The engines are two asynchronous channels, A and B, and one synchronous port. Each source has its own programmable 3-bit request level. The block drives the highest level among the sources that are pending and enabled.

When the CPU runs an interrupt-acknowledge cycle, the block checks whether one of its pending sources sits at the acknowledged level. If so, it joins inter-module arbitration with its own programmable 4-bit arbitration number. If it wins, it returns an 8-bit vector whose low two bits name the interrupting source.

A small write port programs the three levels, the arbitration number and the 6-bit vector base. Software should choose the base so that every vector it produces lands in 0x40..0xFF. Level and arbitration-number writes made while an acknowledge cycle is open are held back until that cycle closes.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset, `irq_level` is 0, `resp_valid` is 0, all three source levels are 0 and the arbitration number is 0.
- R2: A source whose programmed level is 0 never raises `irq_level` and is never chosen for a vector.
- R3: `irq_level` equals the highest programmed level among the sources whose request is high, or 0 when none is. It follows a request change at the next clock edge.
- R4: When several pending sources share the acknowledged level, the synchronous port wins over channel A, and channel A wins over channel B.
- R5: An acknowledge cycle produces a response only when some pending, enabled source has a level equal to `iack_level`.
- R6: The block wins arbitration only when `arb_in` equals its own arbitration number. Any other value of `arb_in` gives no response.
- R7: While the arbitration number is 0, the block never responds, and the acknowledge cycle is left with no responder.
- R8: The vector is {vector base[5:0], code[1:0]}, where the code is 00 for channel A, 01 for channel B and 10 for the synchronous port.
- R9: `resp_valid` is high for exactly one cycle, in the cycle after the first clock edge of an acknowledge cycle, and at most once per acknowledge cycle.
- R10: The source and the win are decided at the first edge of the acknowledge cycle. Request changes after that edge do not alter the vector.
- R11: Writes to a level or to the arbitration number made while `iack_valid` is held take effect only after the acknowledge cycle ends.
- R12: Write addresses are 0 for the channel A level, 1 for the channel B level, 2 for the synchronous port level (each using wdata[2:0]), 3 for the arbitration number (wdata[3:0]) and 4 for the vector base (wdata[5:0]). With no acknowledge open, a level write shows on `irq_level` three clock edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| req_a | input | 1 | Request from asynchronous channel A |
| req_b | input | 1 | Request from asynchronous channel B |
| req_sp | input | 1 | Request from the synchronous port |
| iack_valid | input | 1 | High for the length of an acknowledge cycle |
| iack_level | input | 3 | Level being acknowledged by the CPU |
| arb_in | input | 4 | Winning arbitration number seen on the bus |
| irq_level | output | 3 | Outgoing request level (0 = none) |
| resp_valid | output | 1 | One-cycle strobe: the block won and drives a vector |
| resp_vector | output | 8 | Interrupt vector, valid with resp_valid |

## Verification
The request pattern is swept through single sources, pairs and all three at distinct levels. This separates a true maximum from first-found or last-found selection. Ties at one level, with each source removed in turn, expose any wrong tie-break order. Acknowledges at an unused level, with a foreign arbitration number and with a zero arbitration number, each tell a missed gate apart from a correct refusal. A write slipped into an open acknowledge cycle, and a request dropped right after the cycle opens, show whether configuration and source choice are frozen at the right edge.

// File: rtl/irqarb_pkg.sv
// Package: shared constants, source encodings and register addresses
// for the three-source serial interrupt arbiter.
package irqarb_pkg;
    localparam int NSRC   = 3;
    localparam int LVL_W  = 3;
    localparam int ARB_W  = 4;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 2;
    localparam int BASE_W = VEC_W - CODE_W;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    // Source indices; the index doubles as the vector code.
    localparam int SRC_A  = 0;
    localparam int SRC_B  = 1;
    localparam int SRC_SP = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_LVL_A  = 3'd0,
        REG_LVL_B  = 3'd1,
        REG_LVL_SP = 3'd2,
        REG_ARB    = 3'd3,
        REG_VBASE  = 3'd4
    } cfg_reg_e;

    // Vector low bits for a source index.
    function automatic logic [CODE_W-1:0] src_code(input int s);
        case (s)
            SRC_A:   return 2'b00;
            SRC_B:   return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    // Source at tie-break rank r (rank 0 is the strongest).
    function automatic int prio_src(input int r);
        case (r)
            0:       return SRC_SP;
            1:       return SRC_A;
            default: return SRC_B;
        endcase
    endfunction
endpackage

// File: rtl/irqarb_cfg.sv
// Configuration store. Writes land in a staged copy. The staged copy is
// moved to the active copy on every edge where hold is low, so level and
// arbitration changes wait until an acknowledge cycle has closed.
// Assumes: hold is the acknowledge-busy flag. The vector base is written
// directly because it is only read at the decision edge.
module irqarb_cfg
    import irqarb_pkg::*;
#(
    parameter int LVL_W_P = LVL_W,
    parameter int ARB_W_P = ARB_W,
    parameter int BASE_W_P = BASE_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    input  logic                              hold,
    output logic [NSRC-1:0][LVL_W_P-1:0]      lvl_act,
    output logic [ARB_W_P-1:0]                arb_act,
    output logic [BASE_W_P-1:0]               vbase
);
    logic [NSRC-1:0][LVL_W_P-1:0] lvl_stg;
    logic [ARB_W_P-1:0]           arb_stg;

    for (genvar s = 0; s < NSRC; s++) begin : g_lvl
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(s);
        // Staged level register of source s.
        always_ff @(posedge clk) begin
            if (!rst_n)                      lvl_stg[s] <= '0;
            else if (we && addr == MY_ADDR)  lvl_stg[s] <= wdata[LVL_W_P-1:0];
        end
        // Active level register: follows the staged copy outside acknowledges.
        always_ff @(posedge clk) begin
            if (!rst_n)     lvl_act[s] <= '0;
            else if (!hold) lvl_act[s] <= lvl_stg[s];
        end
    end

    // Staged arbitration number and vector base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_stg <= '0;
            vbase   <= '0;
        end else if (we) begin
            if (addr == REG_ARB)   arb_stg <= wdata[ARB_W_P-1:0];
            if (addr == REG_VBASE) vbase   <= wdata[BASE_W_P-1:0];
        end
    end

    // Active arbitration number.
    always_ff @(posedge clk) begin
        if (!rst_n)     arb_act <= '0;
        else if (!hold) arb_act <= arb_stg;
    end

    // R11: nothing active moves while an acknowledge stays open.
    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(lvl_act) && $stable(arb_act)));
endmodule

// File: rtl/irqarb_prio.sv
// Priority logic. It registers the highest pending level and, for a given
// acknowledged level, finds the strongest pending source at that level
// using the fixed tie-break order from the package.
// Assumes: requests are synchronous to clk.
module irqarb_prio
    import irqarb_pkg::*;
#(
    parameter int LVL_W_P = LVL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NSRC-1:0]              req,
    input  logic [NSRC-1:0][LVL_W_P-1:0] lvl,
    input  logic [LVL_W_P-1:0]           match_lvl,
    output logic [LVL_W_P-1:0]           irq_level,
    output logic                         hit,
    output logic [CODE_W-1:0]            hit_code
);
    logic [LVL_W_P-1:0] max_lvl;

    // Highest level among pending sources (level 0 never wins).
    always_comb begin
        max_lvl = '0;
        for (int i = 0; i < NSRC; i++)
            if (req[i] && lvl[i] > max_lvl) max_lvl = lvl[i];
    end

    // Strongest pending source at match_lvl; weakest rank is visited first.
    always_comb begin
        hit      = 1'b0;
        hit_code = '0;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (req[prio_src(r)] && lvl[prio_src(r)] != '0 &&
                lvl[prio_src(r)] == match_lvl) begin
                hit      = 1'b1;
                hit_code = src_code(prio_src(r));
            end
        end
    end

    // Registered outgoing request level.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_level <= '0;
        else        irq_level <= max_lvl;
    end

    // R3: with no request pending, the outgoing level is zero.
    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req) == '0) |-> (irq_level == '0));
endmodule

// File: rtl/irqarb_ack.sv
// Acknowledge controller. At the first edge of an acknowledge cycle it
// decides in one step whether the block responds. The conditions are a
// pending source at the acknowledged level, a nonzero own arbitration
// number, and a bus winner equal to that number. On a win it registers
// the vector. busy stays high until iack_valid drops.
module irqarb_ack
    import irqarb_pkg::*;
#(
    parameter int ARB_W_P = ARB_W,
    parameter int BASE_W_P = BASE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iack_valid,
    input  logic [ARB_W_P-1:0]    arb_in,
    input  logic [ARB_W_P-1:0]    arb_own,
    input  logic [BASE_W_P-1:0]   vbase,
    input  logic                  hit,
    input  logic [CODE_W-1:0]     hit_code,
    output logic                  busy,
    output logic                  resp_valid,
    output logic [VEC_W-1:0]      resp_vector
);
    logic start;
    logic win;

    assign start = iack_valid && !busy;
    assign win   = start && hit && (arb_own != '0) && (arb_in == arb_own);

    // Acknowledge tracking, one-shot response and vector capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy        <= 1'b0;
            resp_valid  <= 1'b0;
            resp_vector <= '0;
        end else begin
            busy       <= iack_valid;
            resp_valid <= win;
            if (win) resp_vector <= {vbase, hit_code};
        end
    end

    // R9: the response strobe never lasts two cycles.
    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);
    // R5: a response only follows an open acknowledge.
    p_resp_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(iack_valid));
    // R7: a zero arbitration number never responds.
    p_no_arb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(arb_own) != '0));
    // R8: code 11 is never produced.
    p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_vector[CODE_W-1:0] != 2'b11));
endmodule

// File: rtl/irq_vec_arbiter.sv
// Top level of the three-source serial interrupt level and vector arbiter.
// It joins the configuration store, the priority logic and the
// acknowledge controller.
// Assumes: all inputs are synchronous to clk; iack_valid is held for the
// whole acknowledge cycle and drops for at least one cycle between cycles.
module irq_vec_arbiter
    import irqarb_pkg::*;
#(
    parameter int LVL_W_P  = LVL_W,
    parameter int ARB_W_P  = ARB_W,
    parameter int BASE_W_P = BASE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic                 req_a,
    input  logic                 req_b,
    input  logic                 req_sp,
    input  logic                 iack_valid,
    input  logic [LVL_W_P-1:0]   iack_level,
    input  logic [ARB_W_P-1:0]   arb_in,
    output logic [LVL_W_P-1:0]   irq_level,
    output logic                 resp_valid,
    output logic [VEC_W-1:0]     resp_vector
);
    logic [NSRC-1:0]              req_vec;
    logic [NSRC-1:0][LVL_W_P-1:0] lvl_act;
    logic [ARB_W_P-1:0]           arb_act;
    logic [BASE_W_P-1:0]          vbase;
    logic                         busy;
    logic                         hit;
    logic [CODE_W-1:0]            hit_code;

    // Gather the source requests by index.
    always_comb begin
        req_vec         = '0;
        req_vec[SRC_A]  = req_a;
        req_vec[SRC_B]  = req_b;
        req_vec[SRC_SP] = req_sp;
    end

    irqarb_cfg #(.LVL_W_P(LVL_W_P), .ARB_W_P(ARB_W_P), .BASE_W_P(BASE_W_P)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .hold(busy),
        .lvl_act(lvl_act), .arb_act(arb_act), .vbase(vbase)
    );

    irqarb_prio #(.LVL_W_P(LVL_W_P)) prio_i (
        .clk(clk), .rst_n(rst_n), .req(req_vec), .lvl(lvl_act),
        .match_lvl(iack_level), .irq_level(irq_level),
        .hit(hit), .hit_code(hit_code)
    );

    irqarb_ack #(.ARB_W_P(ARB_W_P), .BASE_W_P(BASE_W_P)) ack_i (
        .clk(clk), .rst_n(rst_n), .iack_valid(iack_valid), .arb_in(arb_in),
        .arb_own(arb_act), .vbase(vbase), .hit(hit), .hit_code(hit_code),
        .busy(busy), .resp_valid(resp_valid), .resp_vector(resp_vector)
    );
endmodule

// File: tb/irq_vec_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_vec_arbiter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       req_a = 1'b0, req_b = 1'b0, req_sp = 1'b0;
    logic       iack_valid = 1'b0;
    logic [2:0] iack_level = '0;
    logic [3:0] arb_in = '0;
    logic [2:0] irq_level;
    logic       resp_valid;
    logic [7:0] resp_vector;

    int n_chk = 0;
    int n_err = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       iack_prev = 1'b0;
    logic       start_seen = 1'b0;
    logic       after_seen = 1'b0;

    always #2 clk = ~clk;

    irq_vec_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_a(req_a), .req_b(req_b), .req_sp(req_sp),
        .iack_valid(iack_valid), .iack_level(iack_level), .arb_in(arb_in),
        .irq_level(irq_level), .resp_valid(resp_valid), .resp_vector(resp_vector)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_req(input logic a, input logic b, input logic sp);
        @(negedge clk);
        req_a = a; req_b = b; req_sp = sp;
        @(negedge clk);
    endtask

    // Driver: open an acknowledge cycle and queue the expected response.
    task automatic ack(input logic [2:0] lvl, input logic [3:0] arb,
                       input logic v, input logic [7:0] vec, input string req);
        @(negedge clk);
        iack_valid = 1'b1; iack_level = lvl; arb_in = arb;
        exp_q.push_back({v, vec});
        tag_q.push_back(req);
        repeat (2) @(negedge clk);
        iack_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: mark the first edge of each acknowledge cycle.
    always @(posedge clk) begin
        iack_prev  <= iack_valid;
        start_seen <= rst_n && iack_valid && !iack_prev;
        after_seen <= start_seen;
    end

    // Monitor: pop the expected response and compare.
    always @(negedge clk) begin
        if (start_seen && exp_q.size() > 0) begin
            logic [8:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {15'd0, resp_valid}, {15'd0, e[8]});
            if (e[8]) check({t, " R8 vector"}, {8'd0, resp_vector}, {8'd0, e[7:0]});
        end
        if (after_seen) check("R9 one-cycle strobe", {15'd0, resp_valid}, 16'd0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 level after reset", {13'd0, irq_level}, 16'd0);
        check("R1 strobe after reset", {15'd0, resp_valid}, 16'd0);
        // R1, R2: levels reset to zero, so pending requests stay silent.
        set_req(1, 1, 1);
        check("R2 zero levels", {13'd0, irq_level}, 16'd0);
        ack(3'd1, 4'd0, 1'b0, 8'h00, "R1 arb reset zero");
        // R12: register map.
        wr(3'd0, 8'd3); wr(3'd1, 8'd5); wr(3'd2, 8'd2);
        wr(3'd3, 8'd5); wr(3'd4, 8'h14);
        check("R12 R3 all pending", {13'd0, irq_level}, 16'd5);
        set_req(1, 0, 0); check("R3 A only", {13'd0, irq_level}, 16'd3);
        set_req(0, 0, 1); check("R3 SP only", {13'd0, irq_level}, 16'd2);
        set_req(1, 0, 1); check("R3 A+SP", {13'd0, irq_level}, 16'd3);
        set_req(0, 0, 0); check("R3 none", {13'd0, irq_level}, 16'd0);
        set_req(1, 1, 0);
        ack(3'd3, 4'd5, 1'b1, 8'h50, "R5 match A");
        ack(3'd5, 4'd5, 1'b1, 8'h51, "R5 match B");
        ack(3'd4, 4'd5, 1'b0, 8'h00, "R5 no source at level");
        ack(3'd3, 4'd7, 1'b0, 8'h00, "R6 foreign arb");
        // R4: ties at level 4.
        wr(3'd0, 8'd4); wr(3'd1, 8'd4); wr(3'd2, 8'd4);
        set_req(1, 1, 1);
        ack(3'd4, 4'd5, 1'b1, 8'h52, "R4 SP beats A,B");
        set_req(1, 1, 0);
        ack(3'd4, 4'd5, 1'b1, 8'h50, "R4 A beats B");
        set_req(0, 1, 0);
        ack(3'd4, 4'd5, 1'b1, 8'h51, "R4 B alone");
        // R2: disable B via level 0.
        wr(3'd1, 8'd0);
        check("R2 disabled B level", {13'd0, irq_level}, 16'd0);
        ack(3'd4, 4'd5, 1'b0, 8'h00, "R2 disabled B no vector");
        wr(3'd1, 8'd4);
        // R10: drop A right after the deciding edge.
        set_req(1, 1, 0);
        @(negedge clk);
        iack_valid = 1'b1; iack_level = 3'd4; arb_in = 4'd5;
        exp_q.push_back({1'b1, 8'h50}); tag_q.push_back("R10 latched source");
        @(negedge clk);
        req_a = 1'b0;
        @(negedge clk);
        iack_valid = 1'b0;
        @(negedge clk);
        // R11: write during an open acknowledge is deferred.
        set_req(1, 0, 0);
        check("R11 before", {13'd0, irq_level}, 16'd4);
        @(negedge clk);
        iack_valid = 1'b1; iack_level = 3'd1; arb_in = 4'd5;
        exp_q.push_back({1'b0, 8'h00}); tag_q.push_back("R11 no match ack");
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 8'd6;
        @(negedge clk);
        cfg_we = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 held during ack", {13'd0, irq_level}, 16'd4);
        iack_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R11 applied after ack", {13'd0, irq_level}, 16'd6);
        // R8: new vector base.
        wr(3'd4, 8'h3F);
        ack(3'd6, 4'd5, 1'b1, 8'hFC, "R8 base 3F A");
        // R7: arbitration number zero.
        wr(3'd3, 8'd0);
        ack(3'd6, 4'd0, 1'b0, 8'h00, "R7 arb zero");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule